// File: doc/BRIEF.md
# Loadable address mask unit

This unit sits on the memory address path, right after the effective-address adder. Each address it receives is bitwise ANDed with a mask register that software loads. Pointer tags kept in the upper bits or in the lower bits are cleared before the address reaches memory. Programs that expect different address widths can run on one machine: software loads a 16-, 24-, 32- or wider mask for each program.

The mask is stored only up to the implemented address width `ADDR_W`. When a write sets any bit above that width, those bits are dropped. A read-back port returns the value that was actually stored. The alignment check runs on the masked address. Because of this, low-order tag bits that the mask clears can never cause a misaligned-access trap. The address path and the trap are combinational from the access inputs. The only storage in the unit is the mask register.

Top module: `addr_mask_unit`

## Requirements
- R1: After reset, the stored mask has all `ADDR_W` low bits set, and the read-back for the default width is 0x000000FFFFFFFFFF.
- R2: In the same cycle as the access, `pa_addr` equals `ea_addr[ADDR_W-1:0]` ANDed with the stored mask. Effective-address bits at or above `ADDR_W` never reach the output.
- R3: A mask write stores only bits `ADDR_W-1:0` of the written word. The read-back always shows the stored value, zero-extended to 64 bits, and never the raw written word.
- R4: A mask write applies to accesses in the cycles after the clock edge that captures it. An access in the same cycle as the write uses the old mask. The mask does not change when no write occurs.
- R5: `ea_size` encodes the access size as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. `misalign_trap` is 1 exactly when `ea_valid` is 1 and any of the low log2(size) bits of the masked address is 1.
- R6: The trap is computed from the masked address. A low-order tag bit that the mask clears does not raise a trap.
- R7: `pa_valid` follows `ea_valid` in the same cycle. `misalign_trap` stays 0 whenever `ea_valid` is 0.
- R8: A mask of 0x3FFFFFFF clears the two high-order tag bits of a 32-bit pointer, so the access goes to the untagged location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mask_wr_en | input | 1 | Mask load strobe |
| mask_wr_data | input | 64 | Mask value to load (clamped on store) |
| mask_rd_data | output | 64 | Stored mask, zero-extended |
| ea_valid | input | 1 | Effective address is valid this cycle |
| ea_addr | input | 64 | Effective address from the adder |
| ea_size | input | 2 | Access size code (0:1B 1:2B 2:4B 3:8B) |
| pa_valid | output | 1 | Masked address is valid |
| pa_addr | output | ADDR_W | Masked address to memory |
| misalign_trap | output | 1 | Misaligned access on the masked address |

## Verification
`pa_addr`, `pa_valid` and `misalign_trap` are due in the same cycle as the access. The bench drives the access at a falling edge and samples one nanosecond later, before any rising edge. A mask write first appears on `mask_rd_data` and in the masking after the next rising edge. The bench therefore checks the result of a write only at the falling edge that follows that edge. In the same-cycle case it samples before the edge, where the old mask must still apply.

// File: rtl/addr_mask_pkg.sv
package addr_mask_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  // All-ones value covering the low 'width' bits of a 64-bit word.
  function automatic logic [63:0] width_limit(input int width);
    if (width >= 64) return '1;
    return (64'd1 << width) - 64'd1;
  endfunction

  // Low-order bits that must be zero for an access of the given size.
  function automatic logic [2:0] align_bits(input acc_size_e sz);
    case (sz)
      SZ_BYTE:  return 3'b000;
      SZ_HALF:  return 3'b001;
      SZ_WORD:  return 3'b011;
      default:  return 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/amask_store.sv
module amask_store
  import addr_mask_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int EA_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [EA_W-1:0]   wr_data,
  output logic [ADDR_W-1:0] mask_q,
  output logic              wr_fire
);
  // Bits above ADDR_W are never stored, so every write is clamped.
  logic [ADDR_W-1:0] clamped;

  assign clamped = wr_data[ADDR_W-1:0];
  assign wr_fire = wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else if (wr_fire) mask_q <= clamped;
  end
endmodule

// File: rtl/amask_gate.sv
module amask_gate #(
  parameter int ADDR_W = 40,
  parameter int EA_W   = 64
) (
  input  logic [EA_W-1:0]   ea,
  input  logic [ADDR_W-1:0] mask,
  output logic [ADDR_W-1:0] masked
);
  // A single AND gate per bit, away from any adder.
  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    assign masked[b] = ea[b] & mask[b];
  end
endmodule

// File: rtl/amask_align.sv
module amask_align
  import addr_mask_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] low_addr,
  input  acc_size_e  size,
  output logic       low_bits_set,
  output logic       trap
);
  assign low_bits_set = |(low_addr & align_bits(size));
  assign trap         = valid & low_bits_set;
endmodule

// File: rtl/addr_mask_unit.sv
module addr_mask_unit
  import addr_mask_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int EA_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr_en,
  input  logic [63:0]       mask_wr_data,
  output logic [63:0]       mask_rd_data,
  input  logic              ea_valid,
  input  logic [63:0]       ea_addr,
  input  logic [1:0]        ea_size,
  output logic              pa_valid,
  output logic [ADDR_W-1:0] pa_addr,
  output logic              misalign_trap
);
  localparam int LOW_W = 3;

  if (ADDR_W < 4 || ADDR_W > EA_W || EA_W != 64) begin : g_bad_cfg
    initial $error("addr_mask_unit: unsupported ADDR_W/EA_W");
  end

  logic [ADDR_W-1:0] mask_q;
  logic              wr_fire;
  logic [ADDR_W-1:0] masked_addr;
  logic              low_bits_set;
  acc_size_e         size_e;

  assign size_e = acc_size_e'(ea_size);

  amask_store #(.ADDR_W(ADDR_W), .EA_W(EA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mask_wr_en),
    .wr_data (mask_wr_data),
    .mask_q  (mask_q),
    .wr_fire (wr_fire)
  );

  amask_gate #(.ADDR_W(ADDR_W), .EA_W(EA_W)) u_gate (
    .ea     (ea_addr),
    .mask   (mask_q),
    .masked (masked_addr)
  );

  amask_align u_align (
    .valid        (ea_valid),
    .low_addr     (masked_addr[LOW_W-1:0]),
    .size         (size_e),
    .low_bits_set (low_bits_set),
    .trap         (misalign_trap)
  );

  assign pa_valid     = ea_valid;
  assign pa_addr      = masked_addr;
  assign mask_rd_data = 64'(mask_q);
endmodule

// File: rtl/amask_checker.sv
module amask_checker
  import addr_mask_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mask_wr_en,
  input logic [63:0]       mask_wr_data,
  input logic [63:0]       mask_rd_data,
  input logic              ea_valid,
  input logic [1:0]        ea_size,
  input logic              pa_valid,
  input logic [ADDR_W-1:0] pa_addr,
  input logic              misalign_trap,
  input logic [ADDR_W-1:0] mask_q,
  input logic [ADDR_W-1:0] masked_addr
);
  localparam logic [63:0] LIM = width_limit(ADDR_W);

  p_out_within_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |-> ((pa_addr & ~mask_q) == '0));

  p_readback_clamped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_rd_data & ~LIM) == 64'd0);

  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_en |=> mask_rd_data == ($past(mask_wr_data) & LIM));

  p_mask_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_en |=> $stable(mask_rd_data));

  p_byte_never_traps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && ea_size == 2'd0) |-> !misalign_trap);

  p_cleared_low_no_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && masked_addr[2:0] == 3'b000) |-> !misalign_trap);

  p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pa_valid == ea_valid);

  p_no_trap_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ea_valid |-> !misalign_trap);
endmodule

bind addr_mask_unit amask_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mask_wr_en    (mask_wr_en),
  .mask_wr_data  (mask_wr_data),
  .mask_rd_data  (mask_rd_data),
  .ea_valid      (ea_valid),
  .ea_size       (ea_size),
  .pa_valid      (pa_valid),
  .pa_addr       (pa_addr),
  .misalign_trap (misalign_trap),
  .mask_q        (mask_q),
  .masked_addr   (masked_addr)
);

// File: tb/tb_addr_mask_unit.sv
`timescale 1ns/1ps
module tb_addr_mask_unit;
  localparam int ADDR_W = 40;
  localparam int NV = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mask_wr_en = 1'b0;
  logic [63:0]       mask_wr_data = '0;
  logic [63:0]       mask_rd_data;
  logic              ea_valid = 1'b0;
  logic [63:0]       ea_addr = '0;
  logic [1:0]        ea_size = '0;
  logic              pa_valid;
  logic [ADDR_W-1:0] pa_addr;
  logic              misalign_trap;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addr_mask_unit #(.ADDR_W(ADDR_W)) dut (.*);

  // Vector table: optional mask write, then one access.
  localparam bit          V_WR   [NV] = '{0, 0, 1, 1, 0, 1, 1, 1};
  localparam logic [63:0] V_WDAT [NV] = '{
    64'h0, 64'h0, 64'h3FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFC,
    64'h0, 64'hFFFF, 64'hFF_FFFF, 64'h0};
  localparam logic [63:0] V_EA   [NV] = '{
    64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF1, 64'hC000_1000,
    64'h2000_0003, 64'h2000_0006, 64'hABCD_1235,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h7};
  localparam logic [1:0]  V_SZ   [NV] = '{3, 1, 2, 2, 3, 0, 3, 3};
  localparam logic [63:0] V_XA   [NV] = '{
    64'h78_9ABC_DEF0, 64'h78_9ABC_DEF1, 64'h1000, 64'h2000_0000,
    64'h2000_0004, 64'h1235, 64'hFF_FFFF, 64'h0};
  localparam bit          V_XT   [NV] = '{0, 1, 0, 0, 1, 0, 1, 0};
  localparam logic [63:0] V_XM   [NV] = '{
    64'hFF_FFFF_FFFF, 64'hFF_FFFF_FFFF, 64'h3FFF_FFFF, 64'hFF_FFFF_FFFC,
    64'hFF_FFFF_FFFC, 64'hFFFF, 64'hFF_FFFF, 64'h0};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_mask(input logic [63:0] v);
    @(negedge clk);
    mask_wr_en = 1'b1; mask_wr_data = v; ea_valid = 1'b0;
    @(negedge clk);
    mask_wr_en = 1'b0;
  endtask

  task automatic access(input logic [63:0] a, input logic [1:0] s);
    ea_valid = 1'b1; ea_addr = a; ea_size = s;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset mask", mask_rd_data, 64'hFF_FFFF_FFFF);
    check("R7 idle valid", 64'(pa_valid), 64'd0);
    rst_n = 1'b1;

    // R2 R3 R5 R6 R8 through the vector table.
    for (int i = 0; i < NV; i++) begin
      if (V_WR[i]) write_mask(V_WDAT[i]);
      else @(negedge clk);
      access(V_EA[i], V_SZ[i]);
      check($sformatf("R2 vec%0d addr", i), 64'(pa_addr), V_XA[i]);
      check($sformatf("R5 vec%0d trap", i), 64'(misalign_trap), 64'(V_XT[i]));
      check($sformatf("R3 vec%0d readback", i), mask_rd_data, V_XM[i]);
      check($sformatf("R7 vec%0d valid", i), 64'(pa_valid), 64'd1);
    end

    // R4: a write in the same cycle as an access leaves that access on the old mask.
    write_mask(64'hFF_FFFF_FFFF);
    @(negedge clk);
    mask_wr_en = 1'b1; mask_wr_data = 64'hF;
    access(64'hFF, 2'd0);
    check("R4 same-cycle old mask", 64'(pa_addr), 64'hFF);
    @(negedge clk);
    mask_wr_en = 1'b0;
    #1;
    check("R4 next-cycle new mask", 64'(pa_addr), 64'hF);
    @(negedge clk); #1;
    check("R4 mask holds", mask_rd_data, 64'hF);

    // R6: a low tag cleared by the mask must not trap; the same pointer unmasked does.
    write_mask(64'hFF_FFFF_FFF8);
    access(64'h1000_0005, 2'd3);
    check("R6 tag stripped no trap", 64'(misalign_trap), 64'd0);
    write_mask(64'hFF_FFFF_FFFF);
    access(64'h1000_0005, 2'd3);
    check("R6 unmasked traps", 64'(misalign_trap), 64'd1);

    // R7: no trap and no valid output without a valid access.
    @(negedge clk);
    ea_valid = 1'b0; ea_addr = 64'h3; ea_size = 2'd3;
    #1;
    check("R7 no trap idle", 64'(misalign_trap), 64'd0);
    check("R7 valid low", 64'(pa_valid), 64'd0);

    // R3: only bits above the width set, so the stored mask becomes zero.
    write_mask(64'hFFFF_FF00_0000_0000);
    check("R3 high-only write", mask_rd_data, 64'h0);

    // R1: reset restores the all-ones mask.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset restores", mask_rd_data, 64'hFF_FFFF_FFFF);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule